// File: doc/BRIEF.md
# Power-Up Strap Sampler for a Shared Clock Pin

This block manages one package pin that serves two purposes in turn. Immediately after the supply becomes good, the pin is an input. An external pull resistor sets its level while the block keeps the pin's output driver switched off. The block then counts a fixed settling window in reference-clock cycles.

When the window closes, the block captures the pin level once, marks the configuration as valid and switches the driver on. From then on the pin carries the reference clock. The captured bit is exported as the rate select of a companion clock output: a low strap selects 48 MHz and a high strap selects 24 MHz. The captured bit can only be cleared by the supply going away and coming back.

The power-good input is the block's only reset and acts asynchronously. A synchroniser chain releases it into the reference-clock domain, and a second chain brings the pin level into that domain before the capture.

Top module: `sd_strap_ctl`

## Requirements
- R1: While `pwr_good` is low, `pad_oe`, `pad_out`, `cfg_valid` and `sel_24m` are all 0.
- R2: After `pwr_good` rises between two clock edges, `cfg_valid` rises on rising edge number WINDOW_CYCLES+RUN_STAGES+1 counted from that rise, and stays 0 before it.
- R3: `pad_oe` is 0 whenever `cfg_valid` is 0. With RETIME_NEG=1, `pad_oe` rises on the first falling clock edge after `cfg_valid` rises.
- R4: The captured bit is the `pad_in` level seen at the rising edge SYNC_STAGES cycles before the edge that raises `cfg_valid`. A low level captures 0 and a high level captures 1. A change after that edge is not captured.
- R5: `sel_24m` equals the captured bit while `cfg_valid` is 1 (1 selects 24 MHz, 0 selects 48 MHz). It is 0 while `cfg_valid` is 0.
- R6: While `pad_oe` is 1, `pad_out` is 1 in the high phase of `ref_clk` and 0 in its low phase.
- R7: Once `cfg_valid` is 1, it and `sel_24m` stay constant for as long as `pwr_good` stays high, whatever `pad_in` does.
- R8: A fall of `pwr_good` forces `pad_oe`, `pad_out`, `cfg_valid` and `sel_24m` to 0 at once, without waiting for a clock edge.
- R9: Each new rise of `pwr_good` starts a full new window, measured from that rise, and captures the strap afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; the timer runs on it and it is forwarded to the pin |
| pwr_good | input | 1 | Supply-good indication, active high; low clears everything asynchronously |
| pad_in | input | 1 | Level seen at the shared pin |
| pad_oe | output | 1 | Output enable of the pin driver; 0 means tri-stated |
| pad_out | output | 1 | Value driven onto the pin when enabled (gated reference clock) |
| cfg_valid | output | 1 | High once the strap has been captured |
| sel_24m | output | 1 | Rate select for the companion output: 1 = 24 MHz, 0 = 48 MHz |

## Verification
The bench builds the block with WINDOW_CYCLES=40 and keeps the default two-stage synchronisers and falling-edge enable retiming. The short window makes the exact edge on which `cfg_valid` rises observable. It also lets the bench move the strap level one cycle either side of the capture edge, and repeat full supply cycles with both strap levels, mid-window drops and drops during clock forwarding. The default 28637-cycle window would only add waiting. The posedge-enable variant is elaborated by a lint run of the RTL; it is not run in the bench.

// File: rtl/sd_pkg.sv
package sd_pkg;
   typedef enum logic [1:0] {
      PH_WAIT   = 2'd0,
      PH_WINDOW = 2'd1,
      PH_LIVE   = 2'd2
   } phase_e;
endpackage

// File: rtl/sd_sync_chain.sv
// Multi-stage synchroniser with asynchronous clear.
module sd_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stg;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stg <= '0;
      else         stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sd_window_timer.sv
// Counts settling cycles; expired stays high once the last count is reached.
module sd_window_timer #(
   parameter int CYCLES = 28637
) (
   input  logic clk,
   input  logic arst_n,
   input  logic clear,
   output logic expired
);
   localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)       cnt <= '0;
      else if (clear)    cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == LAST);
endmodule

// File: rtl/sd_pad_drive.sv
// Output enable register and clock gate for the shared pin.
module sd_pad_drive #(
   parameter bit RETIME_NEG = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic live,
   output logic oe,
   output logic pclk
);
   logic oe_q;

   generate
      if (RETIME_NEG) begin : g_neg
         // enable changes while clk is low: first forwarded pulse is whole
         always_ff @(negedge clk or negedge arst_n) begin
            if (!arst_n) oe_q <= 1'b0;
            else         oe_q <= live;
         end
      end else begin : g_pos
         // enable changes on the rising edge: saves half a cycle
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) oe_q <= 1'b0;
            else         oe_q <= live;
         end
      end
   endgenerate

   assign oe   = oe_q;
   assign pclk = clk & oe_q;
endmodule

// File: rtl/sd_strap_ctl.sv
module sd_strap_ctl #(
   parameter int WINDOW_CYCLES = 28637,
   parameter int RUN_STAGES    = 2,
   parameter int SYNC_STAGES   = 2,
   parameter bit RETIME_NEG    = 1'b1
) (
   input  logic ref_clk,
   input  logic pwr_good,
   input  logic pad_in,
   output logic pad_oe,
   output logic pad_out,
   output logic cfg_valid,
   output logic sel_24m
);
   import sd_pkg::*;

   generate
      if (WINDOW_CYCLES < 2) begin : g_bad_window
         $error("WINDOW_CYCLES must be at least 2");
      end
      if (RUN_STAGES < 2) begin : g_bad_run
         $error("RUN_STAGES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   phase_e phase;
   logic   run;
   logic   pad_s;
   logic   expired;
   logic   strap_q;

   sd_sync_chain #(.STAGES(RUN_STAGES)) u_run (
      .clk    (ref_clk),
      .arst_n (pwr_good),
      .d      (1'b1),
      .q      (run)
   );

   sd_sync_chain #(.STAGES(SYNC_STAGES)) u_pad (
      .clk    (ref_clk),
      .arst_n (pwr_good),
      .d      (pad_in),
      .q      (pad_s)
   );

   sd_window_timer #(.CYCLES(WINDOW_CYCLES)) u_tmr (
      .clk     (ref_clk),
      .arst_n  (pwr_good),
      .clear   (phase != PH_WINDOW),
      .expired (expired)
   );

   always_ff @(posedge ref_clk or negedge pwr_good) begin
      if (!pwr_good) begin
         phase   <= PH_WAIT;
         strap_q <= 1'b0;
      end else begin
         case (phase)
            PH_WAIT:   if (run) phase <= PH_WINDOW;
            PH_WINDOW: if (expired) begin
                          phase   <= PH_LIVE;
                          strap_q <= pad_s;
                       end
            default:   ;
         endcase
      end
   end

   sd_pad_drive #(.RETIME_NEG(RETIME_NEG)) u_drv (
      .clk    (ref_clk),
      .arst_n (pwr_good),
      .live   (phase == PH_LIVE),
      .oe     (pad_oe),
      .pclk   (pad_out)
   );

   assign cfg_valid = (phase == PH_LIVE);
   assign sel_24m   = strap_q;
endmodule

// File: rtl/sd_strap_chk.sv
module sd_strap_chk #(
   parameter int WINDOW_CYCLES = 28637,
   parameter int RUN_STAGES    = 2
) (
   input logic ref_clk,
   input logic pwr_good,
   input logic pad_oe,
   input logic cfg_valid,
   input logic sel_24m
);
   localparam int EXP = WINDOW_CYCLES + RUN_STAGES + 1;
   localparam int NW  = $clog2(EXP + 2) + 1;
   localparam logic [NW-1:0] NMAX = NW'(EXP + 1);

   logic [NW-1:0] n_edge;

   always_ff @(posedge ref_clk or negedge pwr_good) begin
      if (!pwr_good)          n_edge <= '0;
      else if (n_edge < NMAX) n_edge <= n_edge + 1'b1;
   end

   // R1
   power_low_chk: assert property (@(negedge ref_clk)
      !pwr_good |-> (!pad_oe && !cfg_valid && !sel_24m));

   // R2
   window_len_chk: assert property (@(posedge ref_clk) disable iff (!pwr_good)
      $rose(cfg_valid) |-> (n_edge == NW'(EXP)));

   // R3
   tristate_chk: assert property (@(posedge ref_clk) disable iff (!pwr_good)
      !cfg_valid |-> !pad_oe);

   // R5
   sel_low_chk: assert property (@(posedge ref_clk) disable iff (!pwr_good)
      !cfg_valid |-> !sel_24m);

   // R7
   valid_hold_chk: assert property (@(posedge ref_clk) disable iff (!pwr_good)
      cfg_valid |=> cfg_valid);

   // R7
   strap_hold_chk: assert property (@(posedge ref_clk) disable iff (!pwr_good)
      $past(cfg_valid) |-> $stable(sel_24m));
endmodule

bind sd_strap_ctl sd_strap_chk #(
   .WINDOW_CYCLES (WINDOW_CYCLES),
   .RUN_STAGES    (RUN_STAGES)
) u_chk (
   .ref_clk   (ref_clk),
   .pwr_good  (pwr_good),
   .pad_oe    (pad_oe),
   .cfg_valid (cfg_valid),
   .sel_24m   (sel_24m)
);

// File: tb/sim_sd_strap_ctl.sv
`timescale 1ns/1ps
module sim_sd_strap_ctl;
   localparam int W   = 40;
   localparam int RUN = 2;
   localparam int HIT = W + RUN + 1;   // edge raising cfg_valid

   logic ref_clk = 1'b0;
   logic pwr_good = 1'b1;
   logic strap_lvl = 1'b0;
   logic pad_in, pad_oe, pad_out, cfg_valid, sel_24m;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #5 ref_clk = ~ref_clk;

   // pin model: strap resistor while tri-stated, else the driven clock
   assign pad_in = pad_oe ? pad_out : strap_lvl;

   sd_strap_ctl #(.WINDOW_CYCLES(W), .RUN_STAGES(RUN)) u0 (
      .ref_clk   (ref_clk),
      .pwr_good  (pwr_good),
      .pad_in    (pad_in),
      .pad_oe    (pad_oe),
      .pad_out   (pad_out),
      .cfg_valid (cfg_valid),
      .sel_24m   (sel_24m)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge ref_clk);
      #1;
   endtask

   task automatic power_on(input logic lvl);
      strap_lvl = lvl;
      @(posedge ref_clk);
      #2 pwr_good = 1'b1;
   endtask

   // drop supply mid-high-phase and look before any further edge
   task automatic power_off();
      @(posedge ref_clk);
      #2 pwr_good = 1'b0;
      #1;
      chk("R8 oe after drop", pad_oe, 0);
      chk("R8 pad_out after drop", pad_out, 0);
      chk("R8 valid after drop", cfg_valid, 0);
      chk("R8 sel after drop", sel_24m, 0);
      edges(3);
   endtask

   task automatic t_reset();
      edges(2);
      chk("R1 oe", pad_oe, 0);
      chk("R1 pad_out", pad_out, 0);
      chk("R1 valid", cfg_valid, 0);
      chk("R1 sel", sel_24m, 0);
   endtask

   task automatic t_window(input logic lvl);
      power_on(lvl);
      edges(HIT - 1);
      chk("R2 valid before window end", cfg_valid, 0);
      chk("R3 oe during window", pad_oe, 0);
      edges(1);
      chk("R2 valid at window end", cfg_valid, 1);
      chk("R4 captured level", sel_24m, lvl);
      chk("R3 oe waits for falling edge", pad_oe, 0);
      #5;
      chk("R3 oe after falling edge", pad_oe, 1);
      chk("R6 pad_out low phase", pad_out, 0);
      #5;
      chk("R6 pad_out high phase", pad_out, 1);
   endtask

   task automatic t_persist();
      int bad = 0;
      for (int i = 0; i < 30; i++) begin
         strap_lvl = ~strap_lvl;
         edges(1);
         if (cfg_valid !== 1'b1 || sel_24m !== 1'b1) bad++;
      end
      chk("R7 latch held while pin toggles", bad, 0);
      chk("R5 sel reports 24 MHz for strap 1", sel_24m, 1);
   endtask

   task automatic t_boundary();
      power_on(1'b0);
      edges(HIT - 3);              // just after edge W
      strap_lvl = 1'b1;            // seen by first sync stage at W+1
      edges(3);
      chk("R4 late-enough change captured", sel_24m, 1);
      power_off();
      power_on(1'b0);
      edges(HIT - 2);              // just after edge W+1
      strap_lvl = 1'b1;
      edges(2);
      chk("R4 change after sample edge ignored", cfg_valid, 1);
      chk("R4 old level kept", sel_24m, 0);
      power_off();
   endtask

   task automatic t_drop_mid();
      power_on(1'b1);
      edges(20);
      power_off();
      power_on(1'b0);
      edges(HIT - 1);
      chk("R9 window restarted", cfg_valid, 0);
      edges(1);
      chk("R9 valid after full new window", cfg_valid, 1);
      chk("R9 new strap captured", sel_24m, 0);
      chk("R5 sel reports 48 MHz for strap 0", sel_24m, 0);
      power_off();
   endtask

   initial begin
      #3 pwr_good = 1'b0;
      t_reset();
      t_window(1'b1);
      t_persist();
      power_off();
      t_window(1'b0);
      power_off();
      t_boundary();
      t_drop_mid();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule